// File: doc/BRIEF.md
# Byte-Packing DMA Channel

This block is one DMA channel that collects bytes from a narrow peripheral port and stores them in wide memory. It uses dual-address transfers. For each memory word it reads bytes from the peripheral, one at a time, into a private holding register. It then issues a single word write to memory. Each byte read completes a request/acknowledge handshake with the peripheral. Every peripheral cycle drives an address inside a dedicated DMA window, set at a fixed offset above the source pointer. This keeps the peripheral's ordinary select decode apart from the acknowledge.

Software sets up a transfer through a small register port. It writes the source pointer, the destination pointer, a byte count and a control word, and a start bit launches the channel. The channel then runs only on peripheral requests. When the count runs out, it drops its busy flag and sets a done flag. If enabled, it also raises an interrupt, which stays up until software clears the done flag. Software cannot read or write the holding register.

Top module: `byte_pack_dma`

## Requirements
- R1: Register map by word offset on `reg_addr_i`:
  - 0 is the source pointer.
  - 1 is the destination pointer.
  - 2 is the byte count. Bits [1:0] are dropped on write and read back as 0.
  - 3 is control. Writing bit 0 starts the channel and bit 1 is the interrupt enable. Reading returns the enable in bit 1 and busy in bit 0.
  - 4 is status. Bit 0 is done, and writing 1 to it clears it.
  - All registers read 0 after reset.
- R2: A peripheral byte access starts only in the cycle after `dreq_i` was sampled high. While `dreq_i` stays low, `per_rd_o` and `dack_o` stay low.
- R3: Each byte access lasts 3 cycles with `per_rd_o` high throughout. `dack_o` is high in the last two cycles, so there is exactly one acknowledge pulse per byte. `per_addr_o` equals the source pointer plus the window offset (0x800 by default).
- R4: After four byte accesses the channel spends 2 cycles on memory, with `mem_wr_o` high in the second. The first byte taken lands in `mem_wdata_o[31:24]` and the last in [7:0]. With `dreq_i` held high, one word costs 14 cycles.
- R5: Each word write goes to the current destination pointer. The pointer then advances by 4 and the count drops by 4. The source pointer does not change.
- R6: When the count reaches zero, busy clears and done sets. `irq_o` equals done AND the interrupt enable, and it holds until software clears done.
- R7: While busy, writes to the source, destination and count registers are ignored, and so is a start request.
- R8: Starting with a count of zero sets done at once and performs no peripheral or memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| dreq_i | input | 1 | Peripheral transfer request |
| dack_o | output | 1 | Peripheral acknowledge, one pulse per byte |
| per_rd_o | output | 1 | Peripheral read cycle active |
| per_addr_o | output | 32 | Peripheral DMA window address |
| per_data_i | input | 8 | Peripheral read data |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Packed memory write data |
| irq_o | output | 1 | Terminal-count interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 32-bit memory word, an 8-bit peripheral port and a 0x800 window offset. That gives four bytes per word, so lane ordering, the 14-cycle word budget and the step-by-4 pointer arithmetic can all be checked against values worked out by hand. Counts of 0, 8, 12, 13 and 16 bytes exercise the immediate-completion path and the dropped low count bits. They also cover requests that stall or toggle mid-word, and register writes that arrive while the channel is busy.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P1,
    ST_P2,
    ST_P3,
    ST_M1,
    ST_M2
  } dma_state_e;

  localparam logic [2:0] OFS_SRC  = 3'd0;
  localparam logic [2:0] OFS_DST  = 3'd1;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  localparam int CTRL_START = 0;
  localparam int CTRL_IRQEN = 1;
  localparam int CTRL_BUSY  = 0;
  localparam int STAT_DONE  = 0;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          word_done_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          busy_o,
  output logic          last_o,
  output logic          irq_o
);
  localparam int LSB = $clog2(STEP);
  localparam logic [CW-1:0] STEP_V = CW'(STEP);
  localparam logic [AW-1:0] ASTEP  = AW'(STEP);

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic busy_q, done_q, irq_en_q;

  logic wr_src, wr_dst, wr_cnt, wr_ctrl, start_req, clr_done;

  assign wr_src    = reg_wr_i && reg_addr_i == OFS_SRC && !busy_q;
  assign wr_dst    = reg_wr_i && reg_addr_i == OFS_DST && !busy_q;
  assign wr_cnt    = reg_wr_i && reg_addr_i == OFS_CNT && !busy_q;
  assign wr_ctrl   = reg_wr_i && reg_addr_i == OFS_CTRL;
  assign start_req = wr_ctrl && reg_wdata_i[CTRL_START] && !busy_q;
  assign clr_done  = reg_wr_i && reg_addr_i == OFS_STAT && reg_wdata_i[STAT_DONE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_src) src_q <= reg_wdata_i[AW-1:0];
      if (wr_dst) dst_q <= reg_wdata_i[AW-1:0];
      if (wr_cnt) cnt_q <= {reg_wdata_i[CW-1:LSB], {LSB{1'b0}}};
      if (wr_ctrl) irq_en_q <= reg_wdata_i[CTRL_IRQEN];
      if (clr_done) done_q <= 1'b0;
      if (start_req) begin
        if (cnt_q == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          done_q <= 1'b0;
        end
      end
      if (word_done_i && busy_q) begin
        dst_q <= dst_q + ASTEP;
        cnt_q <= cnt_q - STEP_V;
        if (cnt_q == STEP_V) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_SRC:  reg_rdata_o = 32'(src_q);
      OFS_DST:  reg_rdata_o = 32'(dst_q);
      OFS_CNT:  reg_rdata_o = 32'(cnt_q);
      OFS_CTRL: begin
        reg_rdata_o[CTRL_IRQEN] = irq_en_q;
        reg_rdata_o[CTRL_BUSY]  = busy_q;
      end
      OFS_STAT: reg_rdata_o[STAT_DONE] = done_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign busy_o = busy_q;
  assign last_o = cnt_q == STEP_V;
  assign irq_o  = done_q & irq_en_q;

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && busy_q) |=> cnt_q == $past(cnt_q) - STEP_V);
  a_r5_dst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && busy_q) |=> dst_q == $past(dst_q) + ASTEP);
  a_r7_src_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(src_q));
  a_r6_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_done && !wr_ctrl) |=> irq_o);
  a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !busy_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int BPW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic last_i,
  input  logic dreq_i,
  output logic per_rd_o,
  output logic dack_o,
  output logic take_o,
  output logic mem_act_o,
  output logic mem_wr_o,
  output logic word_done_o
);
  localparam int IW = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(BPW - 1);

  dma_state_e state_q, state_d;
  logic [IW-1:0] idx_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (busy_i && dreq_i) state_d = ST_P1;
      ST_P1:   state_d = ST_P2;
      ST_P2:   state_d = ST_P3;
      ST_P3: begin
        if (idx_q == LAST_IDX) state_d = ST_M1;
        else if (dreq_i)       state_d = ST_P1;
        else                   state_d = ST_IDLE;
      end
      ST_M1:   state_d = ST_M2;
      ST_M2:   state_d = (!last_i && dreq_i) ? ST_P1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_P3) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  assign per_rd_o    = state_q inside {ST_P1, ST_P2, ST_P3};
  assign dack_o      = state_q inside {ST_P2, ST_P3};
  assign take_o      = state_q == ST_P3;
  assign mem_act_o   = state_q inside {ST_M1, ST_M2};
  assign mem_wr_o    = state_q == ST_M2;
  assign word_done_o = state_q == ST_M2;

  a_r2_wait_dreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !dreq_i) |=> state_q != ST_P1);
  a_r3_dack_two_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |=> (dack_o ##1 !dack_o));
  a_r3_rd_before_dack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |-> $past(per_rd_o));
  a_r4_mem_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_act_o) |-> $past(state_q) == ST_P3);
endmodule

// File: rtl/dma_packer.sv
module dma_packer #(
  parameter int DW = 32,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [PW-1:0] byte_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] hold_q;

  // shift left: first byte ends up in the top lane
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (take_i) hold_q <= {hold_q[DW-PW-1:0], byte_i};
  end

  assign word_o = hold_q;

  a_r4_lane_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> word_o[PW-1:0] == $past(byte_i));
endmodule

// File: rtl/byte_pack_dma.sv
module byte_pack_dma #(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter int          PW      = 8,
  parameter logic [31:0] WIN_OFS = 32'h0000_0800
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          dreq_i,
  output logic          dack_o,
  output logic          per_rd_o,
  output logic [AW-1:0] per_addr_o,
  input  logic [PW-1:0] per_data_i,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          irq_o
);
  localparam int BPW = DW / PW;

  logic [AW-1:0] src, dst;
  logic [DW-1:0] word;
  logic busy, last, take, mem_act, word_done;

  dma_regs #(.AW(AW), .CW(32), .STEP(BPW)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .word_done_i(word_done), .src_o(src), .dst_o(dst),
    .busy_o(busy), .last_o(last), .irq_o(irq_o)
  );

  dma_seq #(.BPW(BPW)) u_seq (
    .clk_i, .rst_ni, .busy_i(busy), .last_i(last), .dreq_i,
    .per_rd_o, .dack_o, .take_o(take), .mem_act_o(mem_act),
    .mem_wr_o, .word_done_o(word_done)
  );

  dma_packer #(.DW(DW), .PW(PW)) u_pack (
    .clk_i, .rst_ni, .take_i(take), .byte_i(per_data_i), .word_o(word)
  );

  assign per_addr_o  = per_rd_o ? src + AW'(WIN_OFS) : '0;
  assign mem_addr_o  = mem_act ? dst : '0;
  assign mem_wdata_o = mem_act ? word : '0;

  a_r3_no_access_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !per_rd_o) |=> !per_rd_o);
  a_r4_wr_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> busy);
endmodule

// File: tb/byte_pack_dma_tb.sv
module byte_pack_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WIN = 32'h0000_0800;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dreq = 1'b0, dack, per_rd, mem_wr, irq;
  logic [31:0] per_addr, mem_addr, mem_wdata;
  logic [7:0] per_data = '0;

  int tests = 0, fails = 0;
  int cyc = 0;
  int nb, nwords, last_wr_cyc, dack_run;
  int addr_err, word_err, len_err, gap_err, rd_seen;
  bit cont;
  logic [31:0] exp_src, exp_dst;
  logic dack_prev;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  byte_pack_dma u_dut (
    .clk_i(clk), .rst_ni, .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dreq_i(dreq),
    .dack_o(dack), .per_rd_o(per_rd), .per_addr_o(per_addr),
    .per_data_i(per_data), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .irq_o(irq)
  );

  function automatic logic [7:0] pat(int k);
    return 8'(8'h10 + k);
  endfunction

  // peripheral and memory model, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (per_rd) begin
        rd_seen++;
        if (per_addr != exp_src + WIN) addr_err++;
      end
      if (dack && !dack_prev) begin
        per_data = pat(nb);
        nb++;
      end
      if (dack) dack_run++;
      else if (dack_run > 0) begin
        if (dack_run != 2) len_err++;
        dack_run = 0;
      end
      if (mem_wr) begin
        if (mem_addr != exp_dst + 32'(4*nwords)) word_err++;
        if (mem_wdata != {pat(4*nwords), pat(4*nwords+1), pat(4*nwords+2), pat(4*nwords+3)})
          word_err++;
        if (cont && nwords > 0 && (cyc - last_wr_cyc) != 14) gap_err++;
        last_wr_cyc = cyc;
        nwords++;
      end
      dack_prev = dack;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic clear_mon(logic [31:0] s, logic [31:0] dd, bit c);
    nb = 0; nwords = 0; last_wr_cyc = 0; dack_run = 0;
    addr_err = 0; word_err = 0; len_err = 0; gap_err = 0; rd_seen = 0;
    dack_prev = 1'b0; exp_src = s; exp_dst = dd; cont = c;
  endtask

  // mode 0: dreq held high, mode 1: dreq toggles
  task automatic wait_idle(int mode);
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      dreq = (mode == 0) ? 1'b1 : ((cyc % 5) != 0 && (cyc % 7) != 0);
      rd(3'd3, d);
      if (!d[0]) break;
    end
    dreq = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1 reset readback", d, 32'h0);
    end
    check("R6 reset irq", {31'b0, irq}, 32'h0);
    check("R3 reset dack", {31'b0, dack}, 32'h0);
    check("R4 reset mem_wr", {31'b0, mem_wr}, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    clear_mon(32'h4000_1000, 32'h2000_0000, 1'b1);
    wr(3'd0, 32'h4000_1000);
    wr(3'd1, 32'h2000_0000);
    wr(3'd2, 32'd12);
    wr(3'd3, 32'h3);
    wait_idle(0);
    repeat (2) @(negedge clk);
    check("R4 word count", nwords, 3);
    check("R4 packed data/addr", word_err, 0);
    check("R4 14-cycle word", gap_err, 0);
    check("R3 window address", addr_err, 0);
    check("R3 one dack per byte", nb, 12);
    check("R3 dack width", len_err, 0);
    rd(3'd1, d); check("R5 dst advanced", d, 32'h2000_000C);
    rd(3'd2, d); check("R5 count zero", d, 32'h0);
    rd(3'd0, d); check("R5 src held", d, 32'h4000_1000);
    rd(3'd4, d); check("R6 done set", d, 32'h1);
    rd(3'd3, d); check("R6 busy clear", d, 32'h2);
    check("R6 irq raised", {31'b0, irq}, 32'h1);
    repeat (5) @(negedge clk);
    check("R6 irq held", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h1);
    check("R6 irq cleared", {31'b0, irq}, 32'h0);
    rd(3'd4, d); check("R6 done cleared", d, 32'h0);
  endtask

  task automatic t_dreq_gate();
    clear_mon(32'h0000_0100, 32'h0000_4000, 1'b0);
    wr(3'd0, 32'h0000_0100);
    wr(3'd1, 32'h0000_4000);
    wr(3'd2, 32'd8);
    dreq = 1'b0;
    wr(3'd3, 32'h3);
    repeat (30) @(negedge clk);
    check("R2 no read without dreq", rd_seen, 0);
    check("R2 no dack without dreq", nb, 0);
    wait_idle(1);
    repeat (2) @(negedge clk);
    check("R2 words under toggling dreq", nwords, 2);
    check("R2 data under toggling dreq", word_err, 0);
    check("R3 dack count toggling", nb, 8);
    check("R3 dack width toggling", len_err, 0);
    wr(3'd4, 32'h1);
  endtask

  task automatic t_busy_writes();
    logic [31:0] d;
    clear_mon(32'h0000_0200, 32'h0000_8000, 1'b1);
    wr(3'd0, 32'h0000_0200);
    wr(3'd1, 32'h0000_8000);
    wr(3'd2, 32'd16);
    wr(3'd3, 32'h3);
    dreq = 1'b1;
    repeat (20) @(negedge clk);
    wr(3'd1, 32'hDEAD_0000);
    wr(3'd0, 32'hBEEF_0000);
    wr(3'd2, 32'd100);
    wr(3'd3, 32'h3);
    wait_idle(0);
    repeat (2) @(negedge clk);
    check("R7 words unaffected", nwords, 4);
    check("R7 addresses/data unaffected", word_err, 0);
    check("R7 window unaffected", addr_err, 0);
    rd(3'd0, d); check("R7 src write ignored", d, 32'h0000_0200);
    rd(3'd1, d); check("R7 dst write ignored", d, 32'h0000_8010);
    rd(3'd2, d); check("R7 count write ignored", d, 32'h0);
    wr(3'd4, 32'h1);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    clear_mon(32'h0, 32'h0, 1'b0);
    wr(3'd2, 32'd0);
    dreq = 1'b1;
    wr(3'd3, 32'h3);
    rd(3'd4, d); check("R8 done at once", d, 32'h1);
    rd(3'd3, d); check("R8 never busy", d, 32'h2);
    repeat (10) @(negedge clk);
    check("R8 no peripheral access", rd_seen, 0);
    check("R8 no memory write", nwords, 0);
    dreq = 1'b0;
    wr(3'd4, 32'h1);
  endtask

  task automatic t_low_bits();
    logic [31:0] d;
    clear_mon(32'h0000_0300, 32'h0000_C000, 1'b1);
    wr(3'd0, 32'h0000_0300);
    wr(3'd1, 32'h0000_C000);
    wr(3'd2, 32'd13);
    rd(3'd2, d); check("R1 count low bits dropped", d, 32'd12);
    wr(3'd3, 32'h1);
    rd(3'd3, d); check("R1 ctrl readback busy", d, 32'h1);
    wait_idle(0);
    repeat (2) @(negedge clk);
    check("R1 words for count 13", nwords, 3);
    check("R4 data for count 13", word_err, 0);
    rd(3'd4, d); check("R6 done without irq", d, 32'h1);
    check("R6 irq masked", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    clear_mon(32'h0, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_dreq_gate();
    t_busy_writes();
    t_zero();
    t_low_bits();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule